// File: doc/BRIEF.md
# Calendar Timekeeper with Snapshot Register Bank

This block keeps wall-clock time and a calendar. A clock enable that pulses at 32.768 kHz drives a binary prescaler. Each time the prescaler wraps, the core advances by one second. The core holds seconds, minutes, hours, day of week, date, month and year as BCD fields. It rolls each field over at its natural limit, and it works out month lengths and leap years on its own.

Software never touches the core directly. It reads and writes a separate user bank through a simple register bus, and a control register couples that bank to the core. With both control bits clear, the bank follows the core and reads return live time. Raising the freeze bit takes one coherent snapshot, and the bank then holds still so that a multi-byte read cannot tear. Raising the hold bit stops the clock so new time can be written. Clearing the hold bit loads the written values into the core and restarts the prescaler from zero, which lets the time be aligned to an outside reference. A square-wave output carries a prescaler bit, either 512 Hz or 1 Hz, chosen by a control bit.

Top module: `rtc_snapshot_core`

## Requirements
- R1: After reset the control register reads 00h, and the time reads 00 seconds, 00 minutes, 00 hours, day 01, date 01, month 01 and year 00.
- R2: While running, the seconds advance by one after exactly 2^DIV_W accepted pulses of tick_en, and not before.
- R3: Seconds and minutes roll over from 59h to 00h and carry into the next field. Hours roll over from 23h to 00h and carry into day of week and date.
- R4: Day of week counts 1 to 7 and returns from 07h to 01h at midnight.
- R5: After the month's last date, the date goes back to 01h. February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. April, June, September and November have 30 days, and all other months have 31. Month 12h wraps to 01h and increments the year, and year 99h wraps to 00h.
- R6: With control bits R (bit 0) and W (bit 1) both 0, reads of addresses 02h to 08h return the live core time. Address 02h is seconds, 03h minutes, 04h hours, 05h day, 06h date, 07h month and 08h year.
- R7: A write that changes R from 0 to 1 copies the core time into the user bank. That copy includes a second increment that occurs in the same cycle. The bank then stays unchanged while R is 1.
- R8: While W is 1, the prescaler is held at zero, the square wave stays low, and time does not advance. Writes to addresses 02h to 08h take effect only while W is 1 and are ignored otherwise.
- R9: A write that clears W loads the user bank into the core and restarts the prescaler from zero.
- R10: Control bit 2 selects the square wave. When it is 1, the output is prescaler bit SQW_FAST_BIT (512 Hz at the default setting). When it is 0, the output is the prescaler's top bit (1 Hz).
- R11: Written time fields are masked to their widths: 7 bits for seconds and minutes, 6 bits for hours and date, 3 bits for day, 5 bits for month and 8 bits for year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz time-base rate |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr, combinational |
| sqw_out | output | 1 | Square wave, registered by default |

## Verification
The checks on BCD ranges and on the step-to-step relation of the time fields assume that software only ever loads legal calendar values. A field such as FFh would otherwise break the range checks. The checks also assume that tick_en is a one-cycle enable in the clk domain. The stimulus writes only valid BCD dates and times. It drives tick_en either continuously or as a counted run of cycles, so the number of accepted prescaler pulses is always known exactly when a snapshot is taken.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef struct packed {
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] day;
      logic [7:0] hr;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam int AW = 4;

   // bus map: control first, time fields in ascending significance
   localparam logic [AW-1:0] ADR_CTRL = 4'h0;
   localparam logic [AW-1:0] ADR_SEC  = 4'h2;
   localparam logic [AW-1:0] ADR_MIN  = 4'h3;
   localparam logic [AW-1:0] ADR_HR   = 4'h4;
   localparam logic [AW-1:0] ADR_DAY  = 4'h5;
   localparam logic [AW-1:0] ADR_DATE = 4'h6;
   localparam logic [AW-1:0] ADR_MON  = 4'h7;
   localparam logic [AW-1:0] ADR_YR   = 4'h8;

   localparam logic [7:0] MSK_SEC  = 8'h7F;
   localparam logic [7:0] MSK_MIN  = 8'h7F;
   localparam logic [7:0] MSK_HR   = 8'h3F;
   localparam logic [7:0] MSK_DAY  = 8'h07;
   localparam logic [7:0] MSK_DATE = 8'h3F;
   localparam logic [7:0] MSK_MON  = 8'h1F;
   localparam logic [7:0] MSK_YR   = 8'hFF;

   localparam rtc_time_t TIME_AT_RESET = '{
      yr: 8'h00, mon: 8'h01, date: 8'h01, day: 8'h01,
      hr: 8'h00, min: 8'h00, sec: 8'h00};

   // two-digit BCD increment, caller handles the terminal value
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // BCD year divisible by four
   function automatic logic bcd_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV_W        = 15,
   parameter int SQW_FAST_BIT = 5,
   parameter bit SQW_REG      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             clr,
   input  logic             fast_sel,
   output logic             sec_pulse,
   output logic             sqw_out,
   output logic [DIV_W-1:0] cnt_o
);

   localparam int TOP_BIT = DIV_W - 1;

   logic [DIV_W-1:0] cnt_q;
   logic             sqw_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (tick_en) cnt_q <= cnt_q + 1'b1;
   end

   assign sec_pulse = tick_en && !clr && (&cnt_q);
   assign sqw_src   = fast_sel ? cnt_q[SQW_FAST_BIT] : cnt_q[TOP_BIT];
   assign cnt_o     = cnt_q;

   generate
      if (SQW_REG) begin : g_sqw_ff
         logic sqw_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sqw_q <= 1'b0;
            else        sqw_q <= sqw_src;
         end
         assign sqw_out = sqw_q;
      end else begin : g_sqw_comb
         assign sqw_out = sqw_src;
      end
   endgenerate

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t cur,
   output rtc_time_t nxt
);

   rtc_time_t cur_q;
   rtc_time_t adv;

   always_comb begin
      adv = cur_q;
      if (cur_q.sec == 8'h59) begin
         adv.sec = 8'h00;
         if (cur_q.min == 8'h59) begin
            adv.min = 8'h00;
            if (cur_q.hr == 8'h23) begin
               adv.hr  = 8'h00;
               adv.day = (cur_q.day == 8'h07) ? 8'h01 : 8'(cur_q.day + 8'd1);
               if (cur_q.date == month_end(cur_q.mon, cur_q.yr)) begin
                  adv.date = 8'h01;
                  if (cur_q.mon == 8'h12) begin
                     adv.mon = 8'h01;
                     adv.yr  = (cur_q.yr == 8'h99) ? 8'h00 : bcd_inc(cur_q.yr);
                  end else begin
                     adv.mon = bcd_inc(cur_q.mon);
                  end
               end else begin
                  adv.date = bcd_inc(cur_q.date);
               end
            end else begin
               adv.hr = bcd_inc(cur_q.hr);
            end
         end else begin
            adv.min = bcd_inc(cur_q.min);
         end
      end else begin
         adv.sec = bcd_inc(cur_q.sec);
      end
   end

   always_comb begin
      if (load)      nxt = load_val;
      else if (step) nxt = adv;
      else           nxt = cur_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= TIME_AT_RESET;
      else        cur_q <= nxt;
   end

   assign cur = cur_q;

endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
   import rtc_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [7:0]    bus_wdata,
   input  rtc_time_t     core_nxt,
   output logic [7:0]    bus_rdata,
   output rtc_time_t     user_o,
   output logic          snap_o,
   output logic          hold_o,
   output logic          fast_o,
   output logic          load_o
);

   localparam int CTRL_W = 3;

   rtc_time_t         user_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              ctrl_wr;

   assign ctrl_wr = bus_we && (bus_addr == ADR_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         user_q <= TIME_AT_RESET;
         ctrl_q <= '0;
      end else begin
         if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
         if (ctrl_q[1]) begin
            if (bus_we) begin
               case (bus_addr)
                  ADR_SEC:  user_q.sec  <= bus_wdata & MSK_SEC;
                  ADR_MIN:  user_q.min  <= bus_wdata & MSK_MIN;
                  ADR_HR:   user_q.hr   <= bus_wdata & MSK_HR;
                  ADR_DAY:  user_q.day  <= bus_wdata & MSK_DAY;
                  ADR_DATE: user_q.date <= bus_wdata & MSK_DATE;
                  ADR_MON:  user_q.mon  <= bus_wdata & MSK_MON;
                  ADR_YR:   user_q.yr   <= bus_wdata & MSK_YR;
                  default:  ;
               endcase
            end
         end else if (!ctrl_q[0]) begin
            // tracking also takes the snapshot on the edge that sets the freeze bit
            user_q <= core_nxt;
         end
      end
   end

   always_comb begin
      case (bus_addr)
         ADR_CTRL: bus_rdata = {{(8-CTRL_W){1'b0}}, ctrl_q};
         ADR_SEC:  bus_rdata = user_q.sec;
         ADR_MIN:  bus_rdata = user_q.min;
         ADR_HR:   bus_rdata = user_q.hr;
         ADR_DAY:  bus_rdata = user_q.day;
         ADR_DATE: bus_rdata = user_q.date;
         ADR_MON:  bus_rdata = user_q.mon;
         ADR_YR:   bus_rdata = user_q.yr;
         default:  bus_rdata = 8'h00;
      endcase
   end

   assign user_o = user_q;
   assign snap_o = ctrl_q[0];
   assign hold_o = ctrl_q[1];
   assign fast_o = ctrl_q[2];
   assign load_o = ctrl_q[1] && ctrl_wr && !bus_wdata[1];

endmodule

// File: rtl/rtc_snapshot_core.sv
module rtc_snapshot_core
   import rtc_pkg::*;
#(
   parameter int DIV_W        = 15,
   parameter int SQW_FAST_BIT = 5,
   parameter bit SQW_REG      = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [7:0]    bus_wdata,
   output logic [7:0]    bus_rdata,
   output logic          sqw_out
);

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
      if (SQW_FAST_BIT >= DIV_W - 1) begin : g_bad_fast
         $error("SQW_FAST_BIT must lie below the prescaler top bit");
      end
   endgenerate

   rtc_time_t        core_now;
   rtc_time_t        core_nxt;
   rtc_time_t        user_now;
   logic             hold_q;
   logic             snap_q;
   logic             fast_q;
   logic             load;
   logic             sec_pulse;
   logic [DIV_W-1:0] div_cnt;

   rtc_user_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .core_nxt  (core_nxt),
      .bus_rdata (bus_rdata),
      .user_o    (user_now),
      .snap_o    (snap_q),
      .hold_o    (hold_q),
      .fast_o    (fast_q),
      .load_o    (load)
   );

   rtc_prescaler #(
      .DIV_W        (DIV_W),
      .SQW_FAST_BIT (SQW_FAST_BIT),
      .SQW_REG      (SQW_REG)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .clr       (hold_q),
      .fast_sel  (fast_q),
      .sec_pulse (sec_pulse),
      .sqw_out   (sqw_out),
      .cnt_o     (div_cnt)
   );

   rtc_calendar u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (sec_pulse),
      .load     (load),
      .load_val (user_now),
      .cur      (core_now),
      .nxt      (core_nxt)
   );

endmodule

// File: rtl/rtc_snapshot_core_chk.sv
module rtc_snapshot_core_chk
   import rtc_pkg::*;
#(
   parameter int DIV_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold,
   input logic             snap,
   input logic             sec_pulse,
   input logic [DIV_W-1:0] div_cnt,
   input rtc_time_t        core_time,
   input rtc_time_t        user_time
);

   // R8: a held clock never produces a second step
   a_r8_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !sec_pulse);

   // R3: seconds, minutes and hours stay legal BCD within range
   a_r3_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
      (core_time.sec <= 8'h59) && (core_time.sec[3:0] <= 4'd9) &&
      (core_time.min <= 8'h59) && (core_time.min[3:0] <= 4'd9) &&
      (core_time.hr  <= 8'h23) && (core_time.hr[3:0]  <= 4'd9));

   // R4: day of week stays in 1..7
   a_r4_day_range: assert property (@(posedge clk) disable iff (!rst_n)
      (core_time.day >= 8'h01) && (core_time.day <= 8'h07));

   // R2: a second step always changes the core time
   a_r2_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> (core_time != $past(core_time)));

   // R6: live mode keeps the user bank equal to the core
   a_r6_live_track: assert property (@(posedge clk) disable iff (!rst_n)
      (!snap && !hold) |=> (user_time == core_time));

   // R7: frozen bank does not move
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (snap && !hold) |=> $stable(user_time));

   // R9: leaving hold loads the bank and restarts the prescaler
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold) |-> ((div_cnt == '0) && (core_time == $past(user_time))));

endmodule

bind rtc_snapshot_core rtc_snapshot_core_chk #(.DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hold      (hold_q),
   .snap      (snap_q),
   .sec_pulse (sec_pulse),
   .div_cnt   (div_cnt),
   .core_time (core_now),
   .user_time (user_now)
);

// File: tb/rtc_snapshot_core_test.sv
module rtc_snapshot_core_test;
   import rtc_pkg::*;

   localparam int DIV_W = 4;
   localparam int FAST  = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       bus_we = 1'b0;
   logic [3:0] bus_addr = 4'h0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       sqw_out;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } item_t;
   item_t exp_q[$];

   always #5 clk = ~clk;

   rtc_snapshot_core #(.DIV_W(DIV_W), .SQW_FAST_BIT(FAST)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sqw_out(sqw_out));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compare read data against queued expectations
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         check(it.tag, int'(bus_rdata), int'(it.val));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.val = e; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic ticks(input int k);
      @(posedge clk); #1;
      tick_en = 1'b1;
      repeat (k) @(posedge clk);
      #1 tick_en = 1'b0;
   endtask

   task automatic rd_all(input rtc_time_t e, input string tag);
      rd(ADR_SEC, e.sec, tag);   rd(ADR_MIN, e.min, tag);
      rd(ADR_HR, e.hr, tag);     rd(ADR_DAY, e.day, tag);
      rd(ADR_DATE, e.date, tag); rd(ADR_MON, e.mon, tag);
      rd(ADR_YR, e.yr, tag);
   endtask

   // load t under hold, release, snapshot n cycles after the release edge
   task automatic scenario(input rtc_time_t t, input int n, input rtc_time_t e,
                           input string tag);
      tick_en = 1'b1;
      wr(ADR_CTRL, 8'h02);
      wr(ADR_SEC, t.sec);   wr(ADR_MIN, t.min);  wr(ADR_HR, t.hr);
      wr(ADR_DAY, t.day);   wr(ADR_DATE, t.date); wr(ADR_MON, t.mon);
      wr(ADR_YR, t.yr);
      wr(ADR_CTRL, 8'h00);
      repeat (n - 2) @(posedge clk);
      wr(ADR_CTRL, 8'h01);
      rd_all(e, tag);
      repeat (20) @(posedge clk);
      rd(ADR_SEC, e.sec, "R7 frozen");
      wr(ADR_CTRL, 8'h00);
   endtask

   function automatic rtc_time_t mk(input logic [7:0] hr, mi, se, dy, dt, mo, yr);
      rtc_time_t r;
      r.hr = hr; r.min = mi; r.sec = se; r.day = dy; r.date = dt; r.mon = mo; r.yr = yr;
      return r;
   endfunction

   task automatic count_rises(input int exp, input string tag);
      int rises = 0;
      logic prev;
      @(negedge clk); prev = sqw_out;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (sqw_out && !prev) rises++;
         prev = sqw_out;
      end
      check(tag, rises, exp);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      rd(ADR_CTRL, 8'h00, "R1"); rd_all(mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00), "R1");

      // R8: time writes without hold are ignored
      wr(ADR_SEC, 8'h33);
      rd(ADR_SEC, 8'h00, "R8 ignored write");

      // R11: field masking under hold
      wr(ADR_CTRL, 8'h02);
      rd(ADR_CTRL, 8'h02, "R8 ctrl");
      wr(ADR_DAY, 8'hF7);  rd(ADR_DAY, 8'h07, "R11 day");
      wr(ADR_SEC, 8'hD8);  rd(ADR_SEC, 8'h58, "R11 sec");
      wr(ADR_HR, 8'hE3);   rd(ADR_HR, 8'h23, "R11 hr");

      // R8: held prescaler keeps the square wave low
      tick_en = 1'b1;
      count_rises(0, "R8 sqw held");
      tick_en = 1'b0;

      // R6 / R2 with counted ticks, R9 restart from zero
      wr(ADR_SEC, 8'h30);
      wr(ADR_CTRL, 8'h00);
      ticks(15);
      rd(ADR_SEC, 8'h30, "R6 live before step");
      ticks(1);
      rd(ADR_SEC, 8'h31, "R2 live after step");

      // R9 boundary and R7 same-cycle update
      scenario(mk(8'h23, 8'h59, 8'h58, 8'h07, 8'h28, 8'h02, 8'h24), 15,
               mk(8'h23, 8'h59, 8'h58, 8'h07, 8'h28, 8'h02, 8'h24), "R9 no step yet");
      scenario(mk(8'h23, 8'h59, 8'h58, 8'h07, 8'h28, 8'h02, 8'h24), 16,
               mk(8'h23, 8'h59, 8'h59, 8'h07, 8'h28, 8'h02, 8'h24), "R7 pending step");
      // R3 R4 R5 leap day
      scenario(mk(8'h23, 8'h59, 8'h58, 8'h07, 8'h28, 8'h02, 8'h24), 32,
               mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h29, 8'h02, 8'h24), "R5 leap R4 R3");
      // R5 non-leap February
      scenario(mk(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h23), 16,
               mk(8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h23), "R5 feb28");
      // R5 30-day month
      scenario(mk(8'h23, 8'h59, 8'h59, 8'h05, 8'h30, 8'h04, 8'h10), 16,
               mk(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h10), "R5 april");
      // R5 31-day month does not wrap at 30
      scenario(mk(8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h01, 8'h10), 16,
               mk(8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h01, 8'h10), "R5 jan30");
      // R5 year end and century wrap
      scenario(mk(8'h23, 8'h59, 8'h59, 8'h02, 8'h31, 8'h12, 8'h99), 16,
               mk(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h01, 8'h00), "R5 year wrap");
      // R3 hour carry without day change
      scenario(mk(8'h09, 8'h59, 8'h59, 8'h04, 8'h15, 8'h06, 8'h31), 16,
               mk(8'h10, 8'h00, 8'h00, 8'h04, 8'h15, 8'h06, 8'h31), "R3 hour carry");

      // R10 square-wave select
      tick_en = 1'b1;
      wr(ADR_CTRL, 8'h04);
      rd(ADR_CTRL, 8'h04, "R10 ctrl");
      count_rises(64 / (1 << (FAST + 1)), "R10 fast");
      wr(ADR_CTRL, 8'h00);
      count_rises(64 / (1 << DIV_W), "R10 slow");

      repeat (3) @(posedge clk);
      finish_run();
   end

endmodule